// File: doc/BRIEF.md
# Flash Partition Layout Decoder

This block turns a 32-bit flash format word, the version number of the register block that supplied it, and the flash device size in bytes into a partition table. A one-cycle start pulse loads the three inputs. The block then works out how many segments the flash holds, which segment boots by default, and which segment serves as the fallback image. The segments are streamed out in order of increasing index, one per clock cycle, each carrying its start address and its length in bytes.

Two encodings of the format word are understood. The older encoding carries a single configuration code. The newer one packs the segment count, the default and fallback indices, and an optional size for the first segment, counted in 4 KiB pages. When the first segment size is given, a two-segment layout is split unevenly; when it is zero, the flash is split in half. Layouts that cannot be built end the run with an error and produce no segments.

The flash size must be a power of two and at least 4096 bytes. Start pulses that arrive while a run is in progress are dropped.

Top module: `flash_layout_decoder`

## Requirements
- R1: After reset, seg_valid, seg_last, done and error are low, and seg_count, boot_seg, fallback_seg and fallback_valid are zero.
- R2: With fmt_version 0x00000200, the segment count is fmt_word[3:0], the boot index is fmt_word[7:4] and the fallback index is fmt_word[11:8]. These values appear on seg_count, boot_seg and fallback_seg when done is high and error is low.
- R3: With version 0x00000200, a count of 2 and a nonzero fmt_word[31:12], segment 0 spans from 0 with a length equal to fmt_word with bits 11:0 cleared. Segment 1 starts where segment 0 ends and runs to the end of the flash. A first length equal to the flash size is legal and gives segment 1 a length of zero.
- R4: With two segments and a zero first-segment field, each segment is half the flash, and segment 1 starts at size/2.
- R5: With two segments and a first-segment length larger than the flash size, the run ends with done and error high and no segment is emitted.
- R6: A count of 1 gives a single segment (0, size). Counts of 4 and 8 give segments of size/4 and size/8 at addresses index*length. In these cases fmt_word[31:12] has no effect.
- R7: With fmt_version 0x00000100, the code is fmt_word[15:8]. Codes 0 and 1 mean one segment, and codes 2, 4 and 8 mean that many even segments. The boot index is 1 when the code is above 1 and 0 otherwise. The fallback index is 0. All other bits of fmt_word have no effect.
- R8: With version 0x00000100, code 0x81 means two segments with segment 0 fixed at 0x01002000 bytes. If the flash is smaller than that, the run ends with an error.
- R9: fallback_valid is high exactly when the fallback index differs from the boot index and is less than the segment count.
- R10: A version other than 0x00000100 or 0x00000200, a version-0x200 count other than 1, 2, 4 or 8, or a version-0x100 code outside the listed set ends the run with done and error high and no segment emitted.
- R11: If start is sampled at clock edge E, segment j is presented after edge E+2+j. seg_last is high only on the final segment. done is high for one cycle after the edge that follows the final segment, with error low. On an error, done and error appear after edge E+2.
- R12: A start pulse that arrives while a run is in progress is ignored. The run in progress finishes unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the inputs and begins a run when idle |
| fmt_version | input | 32 | Version number of the format encoding |
| fmt_word | input | 32 | Flash format word |
| flash_size | input | SIZE_W | Flash size in bytes (power of two, at least 4096) |
| seg_valid | output | 1 | A segment is presented this cycle |
| seg_index | output | 4 | Index of the presented segment |
| seg_start | output | SIZE_W | Start byte address of the segment |
| seg_len | output | SIZE_W | Length in bytes of the segment |
| seg_last | output | 1 | The presented segment is the final one |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | High with done when the layout is invalid or unknown |
| seg_count | output | 4 | Decoded number of segments |
| boot_seg | output | 4 | Default boot segment index |
| fallback_seg | output | 4 | Fallback segment index |
| fallback_valid | output | 1 | A usable fallback segment exists |

## Verification
The bench builds the block with its default parameters: a 32-bit size path, at most eight segments, and version codes 0x100 and 0x200. A 32-bit size can hold the fixed 0x01002000 legacy split, so the bench tests that split on a 32 MiB flash and its error case on a 16 MiB flash. The runs also cover every legal count, the uneven split up to the point where the first segment fills the whole flash, and fallback indices that equal the boot index or lie beyond the count. Because the expected cycle of each output is counted from the start edge, any change in latency or a missing or extra segment shows up as a mismatch.

// File: rtl/flp_pkg.sv
package flp_pkg;
  // Fixed by the encoding of the format word.
  localparam int WORD_W    = 32;
  localparam int FLD_W     = 4;
  localparam int PAGE_BITS = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_EMIT,
    ST_FAIL,
    ST_FIN
  } flp_state_e;

  typedef struct packed {
    logic [FLD_W-1:0]  count;
    logic [FLD_W-1:0]  dflt;
    logic [FLD_W-1:0]  fb;
    logic [WORD_W-1:0] first_len;  // zero selects the even split
    logic              bad;        // unknown version or unsupported count
  } flp_fmt_t;
endpackage

// File: rtl/flp_format_decode.sv
module flp_format_decode
  import flp_pkg::*;
#(
  parameter logic [WORD_W-1:0] VER_LEGACY         = 32'h0000_0100,
  parameter logic [WORD_W-1:0] VER_CURRENT        = 32'h0000_0200,
  parameter logic [7:0]        LEGACY_SPLIT_CODE  = 8'h81,
  parameter logic [WORD_W-1:0] LEGACY_SPLIT_BYTES = 32'h0100_2000,
  parameter int                MAX_SEGS           = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] ver,
  output flp_fmt_t          fmt
);
  localparam int CODE_LO = 8;
  localparam int CODE_HI = 15;

  // A legal count is a power of two that does not exceed MAX_SEGS.
  function automatic logic legal_count(input logic [7:0] c);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if ((c == 8'(1 << k)) && ((1 << k) <= MAX_SEGS)) ok = 1'b1;
    end
    return ok;
  endfunction

  logic [7:0] code;
  assign code = word[CODE_HI:CODE_LO];

  always_comb begin
    fmt = '0;
    if (ver == VER_CURRENT) begin
      fmt.count     = word[FLD_W-1:0];
      fmt.dflt      = word[2*FLD_W-1:FLD_W];
      fmt.fb        = word[3*FLD_W-1:2*FLD_W];
      fmt.first_len = {word[WORD_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      fmt.bad       = !legal_count({4'b0, word[FLD_W-1:0]});
    end else if (ver == VER_LEGACY) begin
      fmt.dflt = (code > 8'd1) ? FLD_W'(1) : '0;
      fmt.fb   = '0;
      if (code == LEGACY_SPLIT_CODE) begin
        fmt.count     = FLD_W'(2);
        fmt.first_len = LEGACY_SPLIT_BYTES;
      end else if (code == 8'd0) begin
        fmt.count = FLD_W'(1);
      end else if (legal_count(code)) begin
        fmt.count = code[FLD_W-1:0];
      end else begin
        fmt.bad = 1'b1;
      end
    end else begin
      fmt.bad = 1'b1;
    end
  end
endmodule

// File: rtl/flp_layout_calc.sv
module flp_layout_calc
  import flp_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  logic [FLD_W-1:0]  count,
  input  logic [WORD_W-1:0] first_len,
  input  logic [SIZE_W-1:0] size,
  input  logic [FLD_W-1:0]  idx,
  output logic [SIZE_W-1:0] seg_start,
  output logic [SIZE_W-1:0] seg_len,
  output logic              oversize
);
  localparam int CMP_W = (SIZE_W > WORD_W) ? SIZE_W : WORD_W;

  function automatic int unsigned count_log2(input logic [FLD_W-1:0] c);
    int unsigned r;
    r = 0;
    for (int k = 0; k < FLD_W; k++) begin
      if (c[k]) r = k;
    end
    return r;
  endfunction

  logic [CMP_W-1:0]  size_x;
  logic [CMP_W-1:0]  first_x;
  logic [SIZE_W-1:0] split;
  logic [SIZE_W-1:0] even_len;

  assign size_x   = CMP_W'(size);
  assign first_x  = CMP_W'(first_len);
  assign split    = (first_x == '0) ? (size >> 1) : first_x[SIZE_W-1:0];
  assign even_len = size >> count_log2(count);
  assign oversize = (count == FLD_W'(2)) && (first_x != '0) && (first_x > size_x);

  always_comb begin
    case (count)
      FLD_W'(1): begin
        seg_start = '0;
        seg_len   = size;
      end
      FLD_W'(2): begin
        if (idx == '0) begin
          seg_start = '0;
          seg_len   = split;
        end else begin
          seg_start = split;
          seg_len   = size - split;
        end
      end
      default: begin
        seg_len   = even_len;
        seg_start = even_len * SIZE_W'(idx);
      end
    endcase
  end
endmodule

// File: rtl/flp_sequencer.sv
module flp_sequencer
  import flp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bad,
  input  logic [FLD_W-1:0] count,
  output logic             load,
  output logic             snap,
  output logic             fire,
  output logic [FLD_W-1:0] idx,
  output logic             seg_valid,
  output logic [FLD_W-1:0] seg_index,
  output logic             seg_last,
  output logic             done,
  output logic             error
);
  flp_state_e state;
  logic       at_end;

  assign at_end = (idx == count - FLD_W'(1));
  assign load   = (state == ST_IDLE) && start;
  assign snap   = (state == ST_CHECK);
  assign fire   = (state == ST_EMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      seg_valid <= 1'b0;
      seg_index <= '0;
      seg_last  <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      seg_valid <= 1'b0;
      seg_last  <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_CHECK;
        end
        ST_CHECK: begin
          idx   <= '0;
          state <= bad ? ST_FAIL : ST_EMIT;
        end
        ST_FAIL: begin
          done  <= 1'b1;
          error <= 1'b1;
          state <= ST_IDLE;
        end
        ST_EMIT: begin
          seg_valid <= 1'b1;
          seg_index <= idx;
          seg_last  <= at_end;
          idx       <= idx + FLD_W'(1);
          if (at_end) state <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_layout_decoder.sv
module flash_layout_decoder
  import flp_pkg::*;
#(
  parameter int                SIZE_W             = 32,
  parameter int                MAX_SEGS           = 8,
  parameter logic [WORD_W-1:0] VER_LEGACY         = 32'h0000_0100,
  parameter logic [WORD_W-1:0] VER_CURRENT        = 32'h0000_0200,
  parameter logic [7:0]        LEGACY_SPLIT_CODE  = 8'h81,
  parameter logic [WORD_W-1:0] LEGACY_SPLIT_BYTES = 32'h0100_2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       fmt_version,
  input  logic [31:0]       fmt_word,
  input  logic [SIZE_W-1:0] flash_size,
  output logic              seg_valid,
  output logic [3:0]        seg_index,
  output logic [SIZE_W-1:0] seg_start,
  output logic [SIZE_W-1:0] seg_len,
  output logic              seg_last,
  output logic              done,
  output logic              error,
  output logic [3:0]        seg_count,
  output logic [3:0]        boot_seg,
  output logic [3:0]        fallback_seg,
  output logic              fallback_valid
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] ver_q;
  logic [SIZE_W-1:0] size_q;
  flp_fmt_t          fmt;
  logic              load, snap, fire, oversize;
  logic [FLD_W-1:0]  idx;
  logic [SIZE_W-1:0] calc_start, calc_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      ver_q  <= '0;
      size_q <= '0;
    end else if (load) begin
      word_q <= fmt_word;
      ver_q  <= fmt_version;
      size_q <= flash_size;
    end
  end

  flp_format_decode #(
    .VER_LEGACY        (VER_LEGACY),
    .VER_CURRENT       (VER_CURRENT),
    .LEGACY_SPLIT_CODE (LEGACY_SPLIT_CODE),
    .LEGACY_SPLIT_BYTES(LEGACY_SPLIT_BYTES),
    .MAX_SEGS          (MAX_SEGS)
  ) u_decode (
    .word(word_q),
    .ver (ver_q),
    .fmt (fmt)
  );

  flp_layout_calc #(.SIZE_W(SIZE_W)) u_calc (
    .count    (fmt.count),
    .first_len(fmt.first_len),
    .size     (size_q),
    .idx      (idx),
    .seg_start(calc_start),
    .seg_len  (calc_len),
    .oversize (oversize)
  );

  flp_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .bad      (fmt.bad | oversize),
    .count    (fmt.count),
    .load     (load),
    .snap     (snap),
    .fire     (fire),
    .idx      (idx),
    .seg_valid(seg_valid),
    .seg_index(seg_index),
    .seg_last (seg_last),
    .done     (done),
    .error    (error)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_start      <= '0;
      seg_len        <= '0;
      seg_count      <= '0;
      boot_seg       <= '0;
      fallback_seg   <= '0;
      fallback_valid <= 1'b0;
    end else begin
      if (fire) begin
        seg_start <= calc_start;
        seg_len   <= calc_len;
      end
      if (snap) begin
        seg_count      <= fmt.count;
        boot_seg       <= fmt.dflt;
        fallback_seg   <= fmt.fb;
        fallback_valid <= (fmt.fb != fmt.dflt) && (fmt.fb < fmt.count);
      end
    end
  end
endmodule

// File: rtl/flp_checker.sv
module flp_checker #(
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              seg_valid,
  input logic [3:0]        seg_index,
  input logic [SIZE_W-1:0] seg_start,
  input logic [SIZE_W-1:0] seg_len,
  input logic              seg_last,
  input logic              done,
  input logic              error,
  input logic [3:0]        seg_count,
  input logic [3:0]        boot_seg,
  input logic [3:0]        fallback_seg,
  input logic              fallback_valid
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !seg_valid && !done && !error); // R1

  AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    seg_valid && (seg_index != 4'd0) |->
      seg_start == SIZE_W'($past(seg_start) + $past(seg_len))); // R3

  AST_NO_SEG_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !seg_valid); // R5

  AST_FALLBACK_RULE: assert property (@(posedge clk) disable iff (rst)
    done && !error && fallback_valid |->
      (fallback_seg != boot_seg) && (fallback_seg < seg_count)); // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> done); // R10

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_last |=> done && !error && !seg_valid); // R11

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_last |=>
      seg_valid && (seg_index == $past(seg_index) + 4'd1)); // R11

  AST_LAST_INDEX: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_last |-> seg_index == seg_count - 4'd1); // R11
endmodule

bind flash_layout_decoder flp_checker #(.SIZE_W(SIZE_W)) u_flp_checker (
  .clk           (clk),
  .rst           (rst),
  .seg_valid     (seg_valid),
  .seg_index     (seg_index),
  .seg_start     (seg_start),
  .seg_len       (seg_len),
  .seg_last      (seg_last),
  .done          (done),
  .error         (error),
  .seg_count     (seg_count),
  .boot_seg      (boot_seg),
  .fallback_seg  (fallback_seg),
  .fallback_valid(fallback_valid)
);

// File: tb/tb_flash_layout_decoder.sv
`timescale 1ns/1ps
module tb_flash_layout_decoder;
  localparam int          SIZE_W = 32;
  localparam logic [31:0] V1     = 32'h0000_0100;
  localparam logic [31:0] V2     = 32'h0000_0200;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [31:0]       fmt_version = '0;
  logic [31:0]       fmt_word = '0;
  logic [SIZE_W-1:0] flash_size = '0;
  logic              seg_valid, seg_last, done, error, fallback_valid;
  logic [3:0]        seg_index, seg_count, boot_seg, fallback_seg;
  logic [SIZE_W-1:0] seg_start, seg_len;

  flash_layout_decoder #(.SIZE_W(SIZE_W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .fmt_version(fmt_version), .fmt_word(fmt_word), .flash_size(flash_size),
    .seg_valid(seg_valid), .seg_index(seg_index), .seg_start(seg_start),
    .seg_len(seg_len), .seg_last(seg_last), .done(done), .error(error),
    .seg_count(seg_count), .boot_seg(boot_seg), .fallback_seg(fallback_seg),
    .fallback_valid(fallback_valid)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    bit          fin;
    int          idx;
    logic [31:0] st;
    logic [31:0] ln;
    bit          last;
    bit          err;
    int          cnt;
    int          dflt;
    int          fb;
    bit          fbp;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   ended = 1'b0;

  task automatic cmp(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Expected items derived from the requirements.
  task automatic expect_run(input logic [31:0] ver, input logic [31:0] word,
                            input logic [31:0] size, input int at0, input string req);
    int          cnt, dflt, fb;
    logic [31:0] first;
    logic [7:0]  code;
    bit          bad;
    exp_t        e;
    cnt = 0; dflt = 0; fb = 0; first = '0; bad = 1'b0;
    if (ver == V2) begin
      cnt   = int'(word[3:0]);
      dflt  = int'(word[7:4]);
      fb    = int'(word[11:8]);
      first = word & 32'hFFFF_F000;
      if (!(cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8)) bad = 1'b1;
    end else if (ver == V1) begin
      code = word[15:8];
      dflt = (code > 8'd1) ? 1 : 0;
      if (code == 8'h00 || code == 8'h01) cnt = 1;
      else if (code == 8'h02 || code == 8'h04 || code == 8'h08) cnt = int'(code);
      else if (code == 8'h81) begin cnt = 2; first = 32'h0100_2000; end
      else bad = 1'b1;
    end else begin
      bad = 1'b1;
    end
    if (!bad && cnt == 2) begin
      if (first == 0) first = size >> 1;
      else if (size < first) bad = 1'b1;
    end
    if (!bad) begin
      for (int i = 0; i < cnt; i++) begin
        e.at = at0 + i; e.fin = 1'b0; e.idx = i; e.last = (i == cnt - 1);
        e.err = 1'b0; e.cnt = 0; e.dflt = 0; e.fb = 0; e.fbp = 1'b0; e.req = req;
        if (cnt == 1) begin e.st = 0; e.ln = size; end
        else if (cnt == 2) begin
          e.st = (i == 0) ? 32'h0 : first;
          e.ln = (i == 0) ? first : size - first;
        end else begin
          e.ln = size / cnt;
          e.st = e.ln * i;
        end
        q.push_back(e);
      end
    end
    e.at = at0 + (bad ? 0 : cnt); e.fin = 1'b1; e.idx = 0; e.st = 0; e.ln = 0;
    e.last = 1'b0; e.err = bad; e.cnt = cnt; e.dflt = dflt; e.fb = fb;
    e.fbp = (fb != dflt) && (fb < cnt); e.req = req;
    q.push_back(e);
  endtask

  // Monitor: pops and compares whenever the design presents a result.
  always @(negedge clk) begin : monitor
    exp_t e;
    if (!rst && (seg_valid === 1'b1 || done === 1'b1)) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11/R12 unexpected output: actual valid=%0b done=%0b expected none (cycle %0d)",
                 seg_valid, done, cyc);
      end else begin
        e = q.pop_front();
        cmp(e.req, "R11 cycle", 64'(cyc), 64'(e.at));
        cmp(e.req, "done flag", 64'(done), 64'(e.fin));
        if (e.fin) begin
          cmp(e.req, "error", 64'(error), 64'(e.err));
          if (!e.err) begin
            cmp(e.req, "R2 seg_count", 64'(seg_count), 64'(e.cnt));
            cmp(e.req, "R2 boot_seg", 64'(boot_seg), 64'(e.dflt));
            cmp(e.req, "R2 fallback_seg", 64'(fallback_seg), 64'(e.fb));
            cmp(e.req, "R9 fallback_valid", 64'(fallback_valid), 64'(e.fbp));
          end
        end else begin
          cmp(e.req, "seg_index", 64'(seg_index), 64'(e.idx));
          cmp(e.req, "seg_start", 64'(seg_start), 64'(e.st));
          cmp(e.req, "seg_len", 64'(seg_len), 64'(e.ln));
          cmp(e.req, "R11 seg_last", 64'(seg_last), 64'(e.last));
        end
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Driver: one start pulse, expected items pushed, then wait for them.
  task automatic run(input logic [31:0] ver, input logic [31:0] word,
                     input logic [31:0] size, input string req);
    @(negedge clk);
    fmt_version = ver; fmt_word = word; flash_size = size; start = 1'b1;
    expect_run(ver, word, size, cyc + 1 + 2, req);
    @(negedge clk);
    start = 1'b0;
    drain();
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs after reset
    cmp("R1", "seg_valid", 64'(seg_valid), 0);
    cmp("R1", "done", 64'(done), 0);
    cmp("R1", "error", 64'(error), 0);
    cmp("R1", "seg_last", 64'(seg_last), 0);
    cmp("R1", "summary", 64'({seg_count, boot_seg, fallback_seg, fallback_valid}), 0);

    run(V2, 32'h0000_0012, 32'h0200_0000, "R2 R4 R9");
    run(V2, 32'h0100_2012, 32'h0200_0000, "R3");
    run(V2, 32'h0200_0002, 32'h0200_0000, "R3 full-first");
    run(V2, 32'h0400_0012, 32'h0200_0000, "R5");
    run(V2, 32'hABCD_E001, 32'h0100_0000, "R6 count1 R9");
    run(V2, 32'h0000_0214, 32'h0400_0000, "R6 count4 R9");
    run(V2, 32'h1230_0738, 32'h0080_0000, "R6 count8");
    run(V2, 32'h0000_0502, 32'h0200_0000, "R9 beyond count");
    run(V2, 32'h0000_0003, 32'h0200_0000, "R10 count3");
    run(V2, 32'h0000_0000, 32'h0200_0000, "R10 count0");
    run(32'h0000_0300, 32'h0000_0012, 32'h0200_0000, "R10 version");
    run(V1, 32'h0000_0000, 32'h0100_0000, "R7 code0");
    run(V1, 32'h0000_0100, 32'h0100_0000, "R7 code1");
    run(V1, 32'h0000_02FF, 32'h0200_0000, "R7 code2");
    run(V1, 32'hABC0_04FF, 32'h0400_0000, "R7 code4");
    run(V1, 32'h0000_0800, 32'h0100_0000, "R7 code8");
    run(V1, 32'h0000_8100, 32'h0200_0000, "R8 split");
    run(V1, 32'h0000_8100, 32'h0100_0000, "R8 small");
    run(V1, 32'h0000_0300, 32'h0200_0000, "R10 legacy code");

    // R12: a second start while busy must be dropped
    @(negedge clk);
    fmt_version = V2; fmt_word = 32'h0000_0738; flash_size = 32'h0080_0000; start = 1'b1;
    expect_run(V2, 32'h0000_0738, 32'h0080_0000, cyc + 1 + 2, "R12");
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    fmt_version = V1; fmt_word = 32'h0000_0200; flash_size = 32'h0001_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (10) @(negedge clk);

    summary();
    $finish;
  end
endmodule